// File: doc/BRIEF.md
# Programmable Graphics Aperture Decoder

This block defines one memory-mapped window in the physical address space and says, for every address presented to it, whether that address lands inside the window. Accesses that land inside are the ones the fabric hands to the address-translation path, which later remaps them into system memory. The window has two configuration registers. The first is a size register, which holds a mask code. The second is a base register, which uses the usual layout of a memory base-address register: the upper bits hold the window base, and the low attribute bits are read-only.

The size code decides how many low base bits take part in the comparison. Those bits are held at zero, and a write cannot set them. As a result the window always starts on a boundary equal to its own size. Configuration software can size the window in the usual way: it writes all ones to the base register and reads the value back.

The lookup side is purely combinational. A lookup address produces a hit flag and the offset of that address within the window in the same cycle. A register write takes effect on the next clock edge.

Top module: `gfx_aperture_decoder`

## Requirements
- R1: After a synchronous reset the size code is 0, so the window is 256 MB. The base register reads 0x0000_0008.
- R2: The 6-bit size code lives in register bits [5:0]. Code bit i corresponds to base bit 22+i. The lowest set code bit i selects a window of 2^(22+i) bytes, and any higher set bits have no effect. A code of zero selects 256 MB. Window sizes range from 4 MB (code 6'b111111 or any code with bit 0 set) to 256 MB.
- R3: The select value 2'b00 addresses the base register. A write there stores write-data bits [31:22], but only those at positions at or above the selected size's bit. Lower positions read zero, so writing 0xFFFF_FFFF reads back as the size mask with the attribute bits added.
- R4: Base-register bits [3:0] always read 4'b1000, meaning a prefetchable, 32-bit memory window. Bits [21:4] always read zero, whatever is written.
- R5: A write to the size register clears any stored base bit that the new size masks. Bits cleared this way stay zero after a later size change unmasks them, until a base write sets them again.
- R6: lk_hit is 1 exactly when lk_addr[31:N] equals base[31:N], where 2^N is the selected window size.
- R7: lk_offset equals lk_addr[N-1:0] with all higher bits zero.
- R8: The select value 2'b01 addresses the size register. It reads the stored code in bits [5:0] and zero above. Writes to select values 2'b10 and 2'b11 change nothing, and reads of those values return zero.
- R9: lk_hit and lk_offset follow lk_addr within the same cycle. A configuration write changes the read data and the decode from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 00 base, 01 size |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_sel |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Address lies inside the window |
| lk_offset | output | 32 | Offset of lk_addr within the window |

## Verification
The bench builds the block with its default parameters. These are a 4 MB minimum granule and six code bits, which make every window size from 4 MB to 256 MB reachable, including the all-zero 256 MB reset code. The random stimulus mixes tidy thermometer codes with ragged ones, so that the lowest-set-bit rule is exercised. Lookup addresses are drawn both just inside and just outside the window edges. Directed sequences shrink and then enlarge the window to show that base bits, once masked, stay zero until they are written again.

// File: rtl/gad_pkg.sv
package gad_pkg;

    localparam int ADDR_W   = 32;
    localparam int CODE_MAX = 16;
    localparam int ATTR_W   = 4;

    typedef enum logic [1:0] {
        SEL_BASE = 2'b00,
        SEL_SIZE = 2'b01,
        SEL_RSV2 = 2'b10,
        SEL_RSV3 = 2'b11
    } cfg_sel_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] offset;
    } lookup_res_t;

    // Bit position that starts the compared part of the base.
    function automatic int shift_of(input logic [CODE_MAX-1:0] code,
                                    input int min_shift, input int ncodes);
        int sh;
        sh = min_shift + ncodes;
        for (int i = CODE_MAX - 1; i >= 0; i--) begin
            if (i < ncodes && code[i]) sh = min_shift + i;
        end
        return sh;
    endfunction

    // Ones at every address bit that takes part in the comparison.
    function automatic logic [ADDR_W-1:0] keep_of(input logic [CODE_MAX-1:0] code,
                                                  input int min_shift, input int ncodes);
        logic [ADDR_W-1:0] m;
        int sh;
        sh = shift_of(code, min_shift, ncodes);
        for (int k = 0; k < ADDR_W; k++) m[k] = (k >= sh);
        return m;
    endfunction

endpackage

// File: rtl/gad_size_reg.sv
module gad_size_reg
    import gad_pkg::*;
#(
    parameter int MIN_SHIFT = 22,
    parameter int NUM_CODES = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [NUM_CODES-1:0] wcode,
    output logic [NUM_CODES-1:0] code,
    output logic [ADDR_W-1:0]    keep_cur,
    output logic [ADDR_W-1:0]    keep_next
);
    localparam int MAX_SHIFT = MIN_SHIFT + NUM_CODES;

    logic [NUM_CODES-1:0] code_q;
    logic [CODE_MAX-1:0]  cur_wide, nxt_wide;
    int                   cur_shift;

    always_ff @(posedge clk) begin
        if (rst)     code_q <= '0;
        else if (wr) code_q <= wcode;
    end

    always_comb begin
        cur_wide = '0;
        nxt_wide = '0;
        cur_wide[NUM_CODES-1:0] = code_q;
        nxt_wide[NUM_CODES-1:0] = wcode;
        cur_shift = shift_of(cur_wide, MIN_SHIFT, NUM_CODES);
        keep_cur  = keep_of(cur_wide, MIN_SHIFT, NUM_CODES);
        keep_next = keep_of(nxt_wide, MIN_SHIFT, NUM_CODES);
    end

    assign code = code_q;

    assert_size_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(code_q));

    assert_shift_range_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_shift >= MIN_SHIFT) && (cur_shift <= MAX_SHIFT));

endmodule

// File: rtl/gad_base_reg.sv
module gad_base_reg
    import gad_pkg::*;
#(
    parameter int MIN_SHIFT = 22,
    parameter bit PREFETCH  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_base,
    input  logic              wr_size,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] keep_cur,
    input  logic [ADDR_W-1:0] keep_next,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] base_rd
);
    localparam int BASE_W = ADDR_W - MIN_SHIFT;
    localparam int GAP_W  = MIN_SHIFT - ATTR_W;

    logic [BASE_W-1:0] base_q;
    logic [ATTR_W-1:0] attr;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (wr_base)
            base_q <= wdata[ADDR_W-1:MIN_SHIFT] & keep_cur[ADDR_W-1:MIN_SHIFT];
        else if (wr_size)
            base_q <= base_q & keep_next[ADDR_W-1:MIN_SHIFT];
    end

    assign attr      = {PREFETCH, 2'b00, 1'b0};
    assign base_addr = {base_q, {MIN_SHIFT{1'b0}}};
    assign base_rd   = {base_q, {GAP_W{1'b0}}, attr};

    assert_base_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_base || wr_size) |=> $stable(base_q));

    assert_shrink_clear_R5: assert property (@(posedge clk) disable iff (rst)
        wr_size |=> ((base_q & ~keep_cur[ADDR_W-1:MIN_SHIFT]) == '0));

endmodule

// File: rtl/gad_match.sv
module gad_match
    import gad_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] keep,
    output lookup_res_t       res
);
    logic [ADDR_W-1:0] diff;

    genvar g;
    generate
        for (g = 0; g < ADDR_W; g++) begin : g_cmp
            assign diff[g] = keep[g] & (addr[g] ^ base_addr[g]);
        end
    endgenerate

    always_comb begin
        res.hit    = (diff == '0);
        res.offset = addr & ~keep;
    end

endmodule

// File: rtl/gfx_aperture_decoder.sv
module gfx_aperture_decoder
    import gad_pkg::*;
#(
    parameter int MIN_SHIFT = 22,
    parameter int NUM_CODES = 6,
    parameter bit PREFETCH  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] lk_addr,
    output logic        lk_hit,
    output logic [31:0] lk_offset
);
    logic                 wr_base, wr_size;
    logic [NUM_CODES-1:0] code;
    logic [ADDR_W-1:0]    keep_cur, keep_next, base_addr, base_rd;
    lookup_res_t          res;
    cfg_sel_e             sel;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign wr_base = cfg_wr_en && (sel == SEL_BASE);
    assign wr_size = cfg_wr_en && (sel == SEL_SIZE);

    gad_size_reg #(.MIN_SHIFT(MIN_SHIFT), .NUM_CODES(NUM_CODES)) u_size (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_size),
        .wcode    (cfg_wdata[NUM_CODES-1:0]),
        .code     (code),
        .keep_cur (keep_cur),
        .keep_next(keep_next)
    );

    gad_base_reg #(.MIN_SHIFT(MIN_SHIFT), .PREFETCH(PREFETCH)) u_base (
        .clk      (clk),
        .rst      (rst),
        .wr_base  (wr_base),
        .wr_size  (wr_size),
        .wdata    (cfg_wdata),
        .keep_cur (keep_cur),
        .keep_next(keep_next),
        .base_addr(base_addr),
        .base_rd  (base_rd)
    );

    gad_match u_match (
        .addr     (lk_addr),
        .base_addr(base_addr),
        .keep     (keep_cur),
        .res      (res)
    );

    always_comb begin
        case (sel)
            SEL_BASE: cfg_rdata = base_rd;
            SEL_SIZE: cfg_rdata = {{(ADDR_W-NUM_CODES){1'b0}}, code};
            default:  cfg_rdata = '0;
        endcase
    end

    assign lk_hit    = res.hit;
    assign lk_offset = res.offset;

    assert_offset_join_R7: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ((lk_offset | base_addr) == lk_addr));

endmodule

// File: tb/gfx_aperture_decoder_test.sv
module gfx_aperture_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] lk_addr;
    logic        lk_hit;
    logic [31:0] lk_offset;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [5:0]  m_code;
    logic [31:0] m_base;

    always #2.5 clk = ~clk;

    gfx_aperture_decoder uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_offset(lk_offset)
    );

    function automatic int e_shift(input logic [5:0] c);
        for (int i = 0; i < 6; i++) if (c[i]) return 22 + i;
        return 28;
    endfunction

    function automatic logic [31:0] e_keep(input logic [5:0] c);
        return 32'hFFFF_FFFF << e_shift(c);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (sel == 2'b01) begin
            m_code = d[5:0];
            m_base = m_base & e_keep(m_code);
        end else if (sel == 2'b00) begin
            m_base = d & e_keep(m_code);
        end
    endtask

    task automatic read_check(input string req, input logic [1:0] sel);
        logic [31:0] exp;
        cfg_sel = sel;
        #1;
        case (sel)
            2'b00:   exp = m_base | 32'h8;
            2'b01:   exp = {26'd0, m_code};
            default: exp = 32'h0;
        endcase
        chk(req, cfg_rdata, exp);
    endtask

    task automatic look_check(input string req, input logic [31:0] a);
        logic [31:0] k;
        k = e_keep(m_code);
        lk_addr = a;
        #1;
        chk({req, " hit"}, {31'd0, lk_hit}, {31'd0, ((a & k) == m_base)});
        chk("R7 offset", lk_offset, a & ~k);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_sel = 2'b00; cfg_wdata = '0; lk_addr = '0;
        m_code = '0; m_base = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_check("R1 base reset", 2'b00);
        read_check("R1 size reset", 2'b01);
        look_check("R1 R6 reset window", 32'h0FFF_FFFF);
        look_check("R6 above reset window", 32'h1000_0000);

        // R3 R4 all-ones sizing at 4 MB
        cfg_write(2'b01, 32'h0000_003F);
        read_check("R8 size readback", 2'b01);
        cfg_write(2'b00, 32'hFFFF_FFFF);
        read_check("R3 R4 sizing 4MB", 2'b00);
        chk("R3 4MB literal", cfg_rdata, 32'hFFC0_0008);

        // R2 ragged code: lowest set bit 3 -> 32 MB
        cfg_write(2'b01, 32'h0000_0028);
        cfg_write(2'b00, 32'hFFFF_FFFF);
        chk("R2 ragged 32MB", cfg_rdata, 32'hFE00_0008);

        // R5 enlarge to 256 MB then shrink back: bits stay zero
        cfg_write(2'b00, 32'h1234_5678);
        cfg_write(2'b01, 32'h0000_003F);
        cfg_write(2'b00, 32'hABC0_0000);
        cfg_write(2'b01, 32'h0000_0000);
        cfg_write(2'b01, 32'h0000_003F);
        read_check("R5 masked bits stay zero", 2'b00);
        chk("R5 literal", cfg_rdata, 32'hA000_0008);
        look_check("R5 R6 old bits not matched", 32'hABC0_0000);
        look_check("R6 inside after shrink", 32'hA03F_FFFF);

        // R8 unmapped selects
        cfg_write(2'b10, 32'hFFFF_FFFF);
        cfg_write(2'b11, 32'hFFFF_FFFF);
        read_check("R8 rsv2 read", 2'b10);
        read_check("R8 rsv3 read", 2'b11);
        read_check("R8 base unchanged", 2'b00);
        read_check("R8 size unchanged", 2'b01);

        // R9 write visible only after edge
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = 2'b01; cfg_wdata = 32'h0000_0020;
        #1;
        chk("R9 before edge", cfg_rdata, {26'd0, m_code});
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_code = 6'h20; m_base = m_base & e_keep(m_code);
        #1;
        chk("R9 after edge", cfg_rdata, 32'h20);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [31:0] r;
            op = $urandom_range(0, 3);
            r  = $urandom;
            case (op)
                0: if (r[31]) cfg_write(2'b01, 32'h3F << $urandom_range(0, 6));
                   else       cfg_write(2'b01, r);
                1: cfg_write(2'b00, r);
                default: begin
                    logic [31:0] a;
                    if (r[0]) a = m_base | (r & ~e_keep(m_code));
                    else if (r[1]) a = m_base - 32'd1;
                    else a = r;
                    look_check("R6 random", a);
                end
            endcase
            if (n % 8 == 0) begin
                read_check("R3 random base", 2'b00);
                read_check("R2 random size", 2'b01);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule